// File: doc/BRIEF.md
# Register Scoreboard Issue Controller

This block decides, once per clock, whether the instruction waiting in decode of a single-issue integer pipeline may start execution. It keeps one busy bit per architectural register. A register becomes busy when an instruction that writes it starts, and becomes free again in the cycle the result can be taken from the forwarding network. The result is not held back until it has been written into the register file. An instruction that reads or writes a busy register is held in decode. After it starts it never stops, so only fetch and decode ever wait. While it waits, its opcode and register numbers stay in place. Other per-register flags are kept outside this block and go on updating freely.

The add/subtract unit and the load path have fixed latencies, so the controller tracks their results itself with small delay lines. The multiplier takes a variable number of cycles and reports completion with a strobe. For each source operand the block also reports which unit's forwarded result it must take in the current cycle, or that it reads the register file. Register 0 is a constant and is never tracked.

Top module: `sb_issue_ctrl`

## Requirements
- R1: When `dec_valid` is high, exactly one of `issue` and `stall` is high in that cycle. When `dec_valid` is low, both are low.
- R2: An instruction whose nonzero source register (either `dec_src_a` or `dec_src_b`) is busy gets `stall` and does not issue.
- R3: An instruction that writes a nonzero destination that is still busy stalls (write-after-write).
- R4: Register 0 is never marked busy. As a source or destination it never causes a stall, and its bypass select is always 0.
- R5: Operation code 0 is add/subtract. Suppose it issues in cycle t with nonzero destination d. An instruction that needs d stalls in cycles t+1 to t+ALU_LAT and issues in cycle t+ALU_LAT+1. In that cycle the select for that operand is 1.
- R6: Operation code 1 is a load. Suppose it issues in cycle t with nonzero destination d. Readers of d stall in cycles t+1 to t+LD_LAT and issue in cycle t+LD_LAT+1 with select 2. The default LD_LAT of 3 is two execute cycles plus one alignment cycle.
- R7: Operation code 2 is a multiply. It keeps its destination busy until `mul_done` is sampled high with `mul_dst` equal to that destination. A reader may issue in the next cycle, and its select for that operand is then 3.
- R8: Operation code 3 is a store. Its `dec_dst` field is ignored: it neither stalls on a busy register nor marks one busy.
- R9: Completions from different units in the same cycle each free their own register. Readers of both registers may issue together in the following cycle, each operand with its own unit's select code.
- R10: The select for an operand is 0 (register file) in any cycle other than the single cycle after its producer completes.
- R11: Synchronous reset frees every register and clears forwarding state, so the first instruction after reset issues at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_valid | input | 1 | Decode holds an instruction |
| dec_op | input | 2 | Operation class: 0 add, 1 load, 2 multiply, 3 store |
| dec_src_a | input | RW | First source register number |
| dec_src_b | input | RW | Second source register number |
| dec_dst | input | RW | Destination register number |
| mul_done | input | 1 | Multiplier result goes to forwarding next cycle |
| mul_dst | input | RW | Destination register of the finishing multiply |
| issue | output | 1 | Instruction starts execution this cycle |
| stall | output | 1 | Instruction held in decode this cycle |
| sel_a | output | 2 | Source A select: 0 register file, 1 add, 2 load, 3 multiply |
| sel_b | output | 2 | Source B select, same coding as sel_a |

## Verification
The bench builds the block with 16 registers and the default latencies of 2 for add and 3 for load. The small register count lets a short program reuse registers and test them as both sources and destinations. Those latencies make every stall window of the add and load paths a few cycles long, so each boundary cycle can be checked by exact count. The multiply strobe is driven by hand. This lets it coincide with an add completion and arrive after a long wait, and the bench also drives a reset while a result is still in flight.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    OPC_ALU   = 2'd0,
    OPC_LOAD  = 2'd1,
    OPC_MUL   = 2'd2,
    OPC_STORE = 2'd3
  } opc_e;

  typedef enum logic [1:0] {
    SRC_RF   = 2'd0,
    SRC_ALU  = 2'd1,
    SRC_LOAD = 2'd2,
    SRC_MUL  = 2'd3
  } src_sel_e;
endpackage

// File: rtl/sb_lat_pipe.sv
// Fixed-latency tracker: carries a destination tag for LAT cycles.
module sb_lat_pipe #(
  parameter int LAT = 2,
  parameter int RW  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_v,
  input  logic [RW-1:0] in_dst,
  output logic          out_v,
  output logic [RW-1:0] out_dst
);
  logic [LAT-1:0] v_q;
  logic [RW-1:0]  d_q [LAT];

  always_ff @(posedge clk) begin
    if (rst) v_q[0] <= 1'b0;
    else     v_q[0] <= in_v;
    d_q[0] <= in_dst;
  end

  generate
    for (genvar k = 1; k < LAT; k++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) v_q[k] <= 1'b0;
        else     v_q[k] <= v_q[k-1];
        d_q[k] <= d_q[k-1];
      end
    end
  endgenerate

  assign out_v   = v_q[LAT-1];
  assign out_dst = d_q[LAT-1];
endmodule

// File: rtl/sb_busy_table.sv
// One busy bit per register; register 0 is never set.
module sb_busy_table #(
  parameter int NREG = 64,
  parameter int RW   = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            set_v,
  input  logic [RW-1:0]   set_idx,
  input  logic [NREG-1:0] clr_vec,
  output logic [NREG-1:0] busy
);
  logic [NREG-1:0] set_vec;

  always_comb begin
    set_vec = '0;
    if (set_v && set_idx != '0) set_vec[set_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) busy <= '0;
    else     busy <= (busy & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/sb_hazard.sv
// Issue decision and operand source selection for the decode slot.
module sb_hazard import sb_pkg::*; #(
  parameter int NREG = 64,
  parameter int RW   = 6
) (
  input  logic            rst,
  input  logic [NREG-1:0] busy,
  input  logic            dec_valid,
  input  opc_e            op,
  input  logic [RW-1:0]   src_a,
  input  logic [RW-1:0]   src_b,
  input  logic [RW-1:0]   dst,
  input  logic            alu_bv,
  input  logic [RW-1:0]   alu_bd,
  input  logic            ld_bv,
  input  logic [RW-1:0]   ld_bd,
  input  logic            mul_bv,
  input  logic [RW-1:0]   mul_bd,
  output logic            issue,
  output logic            stall,
  output src_sel_e        sel_a,
  output src_sel_e        sel_b
);
  logic hit_a, hit_b, hit_d, blocked;

  function automatic src_sel_e pick(input logic [RW-1:0] r,
                                    input logic av, input logic [RW-1:0] ad,
                                    input logic lv, input logic [RW-1:0] ld,
                                    input logic mv, input logic [RW-1:0] md);
    if (r == '0)              return SRC_RF;
    else if (av && ad == r)   return SRC_ALU;
    else if (lv && ld == r)   return SRC_LOAD;
    else if (mv && md == r)   return SRC_MUL;
    else                      return SRC_RF;
  endfunction

  always_comb begin
    hit_a   = (src_a != '0) && busy[src_a];
    hit_b   = (src_b != '0) && busy[src_b];
    hit_d   = (op != OPC_STORE) && (dst != '0) && busy[dst];
    blocked = hit_a || hit_b || hit_d;
    issue   = dec_valid && !rst && !blocked;
    stall   = dec_valid && !rst && blocked;
    sel_a   = pick(src_a, alu_bv, alu_bd, ld_bv, ld_bd, mul_bv, mul_bd);
    sel_b   = pick(src_b, alu_bv, alu_bd, ld_bv, ld_bd, mul_bv, mul_bd);
  end
endmodule

// File: rtl/sb_issue_ctrl.sv
module sb_issue_ctrl import sb_pkg::*; #(
  parameter int NREG    = 64,
  parameter int ALU_LAT = 2,
  parameter int LD_LAT  = 3,
  localparam int RW     = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec_valid,
  input  logic [1:0]    dec_op,
  input  logic [RW-1:0] dec_src_a,
  input  logic [RW-1:0] dec_src_b,
  input  logic [RW-1:0] dec_dst,
  input  logic          mul_done,
  input  logic [RW-1:0] mul_dst,
  output logic          issue,
  output logic          stall,
  output logic [1:0]    sel_a,
  output logic [1:0]    sel_b
);
  opc_e            op;
  logic [NREG-1:0] busy, clr_vec;
  logic            alu_start, ld_start, writes;
  logic            alu_done_v, ld_done_v;
  logic [RW-1:0]   alu_done_d, ld_done_d;
  logic            alu_bv, ld_bv, mul_bv;
  logic [RW-1:0]   alu_bd, ld_bd, mul_bd;
  src_sel_e        sa, sb;

  assign op        = opc_e'(dec_op);
  assign writes    = issue && (op != OPC_STORE) && (dec_dst != '0);
  assign alu_start = writes && (op == OPC_ALU);
  assign ld_start  = writes && (op == OPC_LOAD);

  sb_hazard #(.NREG(NREG), .RW(RW)) u_hazard (
    .rst(rst), .busy(busy), .dec_valid(dec_valid), .op(op),
    .src_a(dec_src_a), .src_b(dec_src_b), .dst(dec_dst),
    .alu_bv(alu_bv), .alu_bd(alu_bd), .ld_bv(ld_bv), .ld_bd(ld_bd),
    .mul_bv(mul_bv), .mul_bd(mul_bd),
    .issue(issue), .stall(stall), .sel_a(sa), .sel_b(sb)
  );

  assign sel_a = sa;
  assign sel_b = sb;

  sb_lat_pipe #(.LAT(ALU_LAT), .RW(RW)) u_alu_pipe (
    .clk(clk), .rst(rst), .in_v(alu_start), .in_dst(dec_dst),
    .out_v(alu_done_v), .out_dst(alu_done_d)
  );

  sb_lat_pipe #(.LAT(LD_LAT), .RW(RW)) u_ld_pipe (
    .clk(clk), .rst(rst), .in_v(ld_start), .in_dst(dec_dst),
    .out_v(ld_done_v), .out_dst(ld_done_d)
  );

  always_comb begin
    clr_vec = '0;
    if (alu_done_v) clr_vec[alu_done_d] = 1'b1;
    if (ld_done_v)  clr_vec[ld_done_d]  = 1'b1;
    if (mul_done)   clr_vec[mul_dst]    = 1'b1;
  end

  sb_busy_table #(.NREG(NREG), .RW(RW)) u_busy (
    .clk(clk), .rst(rst), .set_v(writes), .set_idx(dec_dst),
    .clr_vec(clr_vec), .busy(busy)
  );

  // Forwarding tags: valid in the cycle after a unit completes.
  always_ff @(posedge clk) begin
    if (rst) begin
      alu_bv <= 1'b0;
      ld_bv  <= 1'b0;
      mul_bv <= 1'b0;
    end else begin
      alu_bv <= alu_done_v;
      ld_bv  <= ld_done_v;
      mul_bv <= mul_done && (mul_dst != '0);
    end
    alu_bd <= alu_done_d;
    ld_bd  <= ld_done_d;
    mul_bd <= mul_dst;
  end
endmodule

// File: rtl/sb_issue_checker.sv
module sb_issue_checker #(
  parameter int NREG = 64,
  localparam int RW  = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst,
  input logic          dec_valid,
  input logic [1:0]    dec_op,
  input logic [RW-1:0] dec_src_a,
  input logic [RW-1:0] dec_src_b,
  input logic [RW-1:0] dec_dst,
  input logic          mul_done,
  input logic [RW-1:0] mul_dst,
  input logic          issue,
  input logic          stall,
  input logic [1:0]    sel_a,
  input logic [1:0]    sel_b
);
  AST_ONE_OF_ISSUE_STALL: assert property (@(posedge clk) disable iff (rst)
    (issue || stall) == dec_valid && !(issue && stall)); // R1

  AST_ZERO_REGS_ISSUE: assert property (@(posedge clk) disable iff (rst)
    (dec_valid && dec_src_a == '0 && dec_src_b == '0 && dec_dst == '0) |-> issue); // R4

  AST_ZERO_SRC_FROM_RF: assert property (@(posedge clk) disable iff (rst)
    (dec_src_a == '0) |-> (sel_a == 2'd0)); // R4

  AST_FRESH_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    ($past(issue && dec_op != 2'd3 && dec_dst != '0) && dec_valid &&
     dec_src_a == $past(dec_dst)) |-> !issue); // R2

  AST_MUL_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst && mul_done && mul_dst != '0) &&
     !$past(issue && dec_op != 2'd3 && dec_dst == mul_dst) &&
     dec_valid && dec_src_a == $past(mul_dst) && dec_src_b == '0 && dec_dst == '0)
    |-> (issue && sel_a == 2'd3)); // R7
endmodule

bind sb_issue_ctrl sb_issue_checker #(.NREG(NREG)) u_chk (.*);

// File: tb/test_sb_issue_ctrl.sv
module test_sb_issue_ctrl;
  localparam int NREG = 16;
  localparam int RW   = 4;
  localparam int ALAT = 2;
  localparam int LLAT = 3;

  logic          clk = 1'b0;
  logic          rst;
  logic          dec_valid;
  logic [1:0]    dec_op;
  logic [RW-1:0] dec_src_a, dec_src_b, dec_dst;
  logic          mul_done;
  logic [RW-1:0] mul_dst;
  logic          issue, stall;
  logic [1:0]    sel_a, sel_b;

  int n_tests = 0;
  int n_fail  = 0;

  // Behavioural reference state
  bit m_busy [NREG];
  int m_cnt  [NREG];   // >0 cycles left, -1 waits for multiply strobe
  int m_cls  [NREG];
  int m_byp  [NREG];
  bit last_issue;

  always #10 clk = ~clk;

  sb_issue_ctrl #(.NREG(NREG), .ALU_LAT(ALAT), .LD_LAT(LLAT)) i_sb_issue_ctrl (
    .clk(clk), .rst(rst), .dec_valid(dec_valid), .dec_op(dec_op),
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b), .dec_dst(dec_dst),
    .mul_done(mul_done), .mul_dst(mul_dst),
    .issue(issue), .stall(stall), .sel_a(sel_a), .sel_b(sel_b)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int r = 0; r < NREG; r++) begin
      m_busy[r] = 0; m_cnt[r] = 0; m_cls[r] = 0; m_byp[r] = 0;
    end
  endtask

  // One cycle: drive at negedge, compare, then advance the model at posedge.
  task automatic step(input bit v, input int op, input int a, input int b, input int d,
                      input bit md, input int mdst, input string tag);
    bit haz, ei;
    int nb [NREG];
    dec_valid = v; dec_op = op[1:0]; dec_src_a = a[RW-1:0];
    dec_src_b = b[RW-1:0]; dec_dst = d[RW-1:0];
    mul_done = md; mul_dst = mdst[RW-1:0];
    #2;
    haz = (a != 0 && m_busy[a]) || (b != 0 && m_busy[b]) || (op != 3 && d != 0 && m_busy[d]);
    ei  = v && !haz;
    chk(tag, "issue", int'(issue), int'(ei));
    chk(tag, "stall", int'(stall), int'(v && haz));
    chk(tag, "sel_a", int'(sel_a), (a == 0) ? 0 : m_byp[a]);
    chk(tag, "sel_b", int'(sel_b), (b == 0) ? 0 : m_byp[b]);
    last_issue = ei;
    @(posedge clk);
    for (int r = 0; r < NREG; r++) begin
      nb[r] = 0;
      if (m_busy[r] && m_cnt[r] > 0) begin
        m_cnt[r]--;
        if (m_cnt[r] == 0) begin m_busy[r] = 0; nb[r] = m_cls[r]; end
      end
    end
    if (md && mdst != 0 && m_busy[mdst] && m_cnt[mdst] < 0) begin
      m_busy[mdst] = 0; nb[mdst] = 3;
    end
    if (ei && op != 3 && d != 0) begin
      m_busy[d] = 1;
      m_cnt[d]  = (op == 0) ? ALAT : (op == 1) ? LLAT : -1;
      m_cls[d]  = op + 1;
    end
    for (int r = 0; r < NREG; r++) m_byp[r] = nb[r];
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  // Hold one instruction in decode until it issues; return cycles waited.
  task automatic present(input int op, input int a, input int b, input int d,
                         input string tag, output int waited);
    waited = 0;
    for (int k = 0; k < 20; k++) begin
      step(1, op, a, b, d, 0, 0, tag);
      if (last_issue) break;
      waited++;
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    dec_valid = 0; mul_done = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_clear();
  endtask

  initial begin
    int w;
    rst = 1'b1; dec_valid = 0; dec_op = 0; dec_src_a = 0; dec_src_b = 0;
    dec_dst = 0; mul_done = 0; mul_dst = 0;
    model_clear();
    @(negedge clk);
    do_reset();

    // R11 / R1: reset state, idle decode
    idle("R1");
    present(0, 1, 2, 3, "R11", w);
    chk("R11", "wait after reset", w, 0);

    // R5: back-to-back dependent add stalls ALU_LAT cycles, forwarded from add
    present(0, 3, 0, 4, "R5", w);
    chk("R5", "add dependency stall", w, ALAT);

    // R6 / R2: load into 5, reader through source B
    present(1, 1, 0, 5, "R6", w);
    present(0, 0, 5, 6, "R6", w);
    chk("R6", "load dependency stall", w, LLAT);
    idle("R10");
    idle("R10");

    // R3: write-after-write on busy destination
    present(0, 1, 1, 7, "R3", w);
    present(0, 0, 0, 7, "R3", w);
    chk("R3", "waw stall", w, ALAT);
    idle("R1");
    idle("R1");

    // R4: register 0 as destination and as source
    present(0, 1, 2, 0, "R4", w);
    present(0, 0, 0, 0, "R4", w);
    chk("R4", "r0 stall", w, 0);

    // R8: store ignores destination field, even a busy one
    present(0, 1, 0, 8, "R8", w);
    present(3, 1, 2, 8, "R8", w);
    chk("R8", "store on busy dst", w, 0);
    present(3, 0, 0, 9, "R8", w);
    present(0, 9, 0, 0, "R8", w);
    chk("R8", "store marks nothing", w, 0);
    idle("R1");
    idle("R1");

    // R7: multiply waits for its strobe
    present(2, 1, 2, 10, "R7", w);
    for (int k = 0; k < 5; k++) step(1, 0, 10, 0, 0, 0, 0, "R7");
    step(1, 0, 10, 0, 0, 1, 10, "R7");
    step(1, 0, 10, 0, 0, 0, 0, "R7");
    chk("R7", "issue after strobe", int'(last_issue), 1);
    // R10: one cycle later the operand comes from the register file
    step(1, 0, 10, 0, 0, 0, 0, "R10");

    // R9: multiply and add finish in the same cycle
    step(1, 2, 0, 0, 11, 0, 0, "R9");
    step(1, 0, 0, 0, 12, 0, 0, "R9");
    idle("R9");
    step(0, 0, 0, 0, 0, 1, 11, "R9");
    step(1, 0, 11, 12, 13, 0, 0, "R9");
    chk("R9", "joint release", int'(last_issue), 1);
    idle("R1");
    idle("R1");
    idle("R1");

    // R11: reset in flight frees the register
    present(1, 0, 0, 14, "R11", w);
    do_reset();
    present(0, 14, 0, 0, "R11", w);
    chk("R11", "wait after mid-flight reset", w, 0);

    // R2 / R10 mixed: load into 15, add reads it via A after reset of state
    present(1, 0, 0, 15, "R2", w);
    present(0, 15, 15, 1, "R2", w);
    chk("R2", "both sources busy", w, LLAT);
    repeat (4) idle("R10");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule